// File: doc/BRIEF.md
# Multi-Layout Sample Snapshot Buffer

This block records a burst of samples from one of two tap points in a filter datapath: the stream that enters the filter or the stream that leaves it. Each stream carries two lanes (path A and path B) under one valid strobe. A host arms a capture by writing a control register. The block then fills its storage from the chosen stream and stops by itself once the buffer for the selected layout is full. The host reads the captured block back over a small memory-mapped bus, for example to compute adaptive coefficient updates.

Four storage layouts are offered: a single buffer of 512 narrow samples, a single buffer of 256 full-width samples, a pair of buffers of 256 narrow samples each, or a pair of buffers of 128 full-width samples each. A narrow sample is the upper half of a 16-bit sample, and two of them share one host word. The storage is ping-ponged between two pages. A capture fills the hidden page and becomes visible only when it completes, so host reads during a capture still see the last completed block.

The host bus has a 16-bit data path, split into a write half, a read half and a read-drive enable; a 9-bit word address; a read/write line; and a select strobe. Control registers sit in the lower half of the 512-word space and the snapshot words sit in the upper half.

Top module: `snap_capture`

## Requirements
- R1: After reset, the status register (address 1) reads 0, the control register (address 0) reads 0, and `host_rdata_en` is low.
- R2: A host write to address 1 while idle starts a capture: the status reads busy (bit 0 = 1, bit 1 = 0). A write to address 1 while busy is ignored and does not restart the count.
- R3: A capture stops after exactly the layout's sample count per buffer. Layout code 0 takes 512 samples, codes 1 and 2 take 256, and code 3 takes 128. Busy then clears and done (status bit 1) sets. Done stays set until the next arm, and busy and done are never set together.
- R4: Control bit 2 selects the source: 0 is the filter-input stream (`in_*`) and 1 is the filter-output stream (`out_*`). Only cycles where the selected stream's valid is high record a sample, and the other stream has no effect.
- R5: In the full-width single layout (control bits 1:0 = 1), sample i of lane A is read unchanged at host address 256 + i.
- R6: In the narrow layouts (codes 0 and 2), each sample keeps its upper 8 bits. Samples 2k and 2k+1 share one word: the earlier sample goes in bits 7:0 and the later sample in bits 15:8. Code 0 fills words 256..511 from lane A.
- R7: In the dual layouts (codes 2 and 3), lane A fills addresses 256..383 and lane B fills 384..511. Both lanes are written on the same valid cycle.
- R8: Snapshot reads while a capture runs return the previously completed block. The new block becomes readable in the cycle after done sets.
- R9: Host writes to snapshot addresses (256..511) are ignored. Writes to the control register while busy are ignored.
- R10: `host_rdata` and `host_rdata_en` become valid on the clock edge that follows a read strobe. `host_rdata_en` is low in every other cycle, and control addresses other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Filter-input stream sample valid |
| in_a | input | 16 | Filter-input stream, lane A |
| in_b | input | 16 | Filter-input stream, lane B |
| out_vld | input | 1 | Filter-output stream sample valid |
| out_a | input | 16 | Filter-output stream, lane A |
| out_b | input | 16 | Filter-output stream, lane B |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | 9 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_en | output | 1 | Drive enable for the read data |

## Verification
The assertions watch, on every cycle, the control sequencing: that an idle arm always yields busy, that done persists until the next arm and never coexists with busy, that the sample count sits at zero when idle, that the visible page flips exactly when a capture completes, that configuration holds still during a capture, and the one-cycle read-enable timing. Packing order, byte selection, lane placement, source selection under valid gaps, exact capture lengths and the visibility of old data during a new capture depend on the data values. Only the bench scenarios show these, by comparing every read-back word against patterns computed independently.

// File: rtl/snap_capture.sv
module snap_capture #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [SW-1:0] in_a,
  input  logic [SW-1:0] in_b,
  input  logic          out_vld,
  input  logic [SW-1:0] out_a,
  input  logic [SW-1:0] out_b,
  input  logic          host_sel,
  input  logic          host_rd,
  input  logic [8:0]    host_addr,
  input  logic [SW-1:0] host_wdata,
  output logic [SW-1:0] host_rdata,
  output logic          host_rdata_en
);
  localparam int HB = SW / 2;
  localparam int BW = 128;

  logic [SW-1:0] cfg;
  logic          busy, done, vis_pg;
  logic [8:0]    cnt, last;
  logic [SW-1:0] rbank [2];

  wire       wr   = host_sel & ~host_rd;
  wire       rd   = host_sel & host_rd;
  wire       arm  = wr && host_addr == 9'd1 && !busy;
  wire [1:0] lay  = cfg[1:0];
  wire       dual = lay[1];
  wire       nar  = ~lay[0];
  wire       src  = cfg[2];
  wire       svld = busy && (src ? out_vld : in_vld);

  wire [SW-1:0] sa = src ? out_a : in_a;
  wire [SW-1:0] sb = src ? out_b : in_b;
  wire [SW-1:0] sa_w = nar ? {sa[SW-1 -: HB], sa[SW-1 -: HB]} : sa;
  wire [SW-1:0] sb_w = nar ? {sb[SW-1 -: HB], sb[SW-1 -: HB]} : sb;
  wire [6:0]    wi   = nar ? cnt[7:1] : cnt[6:0];
  wire          bsel = nar ? cnt[8] : cnt[7];
  wire [1:0]    be   = nar ? (cnt[0] ? 2'b10 : 2'b01) : 2'b11;

  always_comb begin
    case (lay)
      2'd0:    last = 9'd511;
      2'd1:    last = 9'd255;
      2'd2:    last = 9'd255;
      default: last = 9'd127;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      vis_pg <= 1'b0;
      cnt    <= '0;
    end else begin
      if (wr && host_addr == 9'd0 && !busy) cfg <= host_wdata;
      if (arm) begin
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= '0;
      end else if (svld) begin
        if (cnt == last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          vis_pg <= ~vis_pg;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 9'd1;
        end
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_bank
    logic [SW-1:0] mem [2*BW];
    wire           we = svld && (dual || bsel == 1'(k));
    wire [SW-1:0]  d  = (k == 0 || !dual) ? sa_w : sb_w;
    always_ff @(posedge clk) begin
      if (we) begin
        if (be[0]) mem[{~vis_pg, wi}][HB-1:0]  <= d[HB-1:0];
        if (be[1]) mem[{~vis_pg, wi}][SW-1:HB] <= d[SW-1:HB];
      end
    end
    assign rbank[k] = mem[{vis_pg, host_addr[6:0]}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata    <= '0;
      host_rdata_en <= 1'b0;
    end else begin
      host_rdata_en <= rd;
      if (rd) begin
        if (host_addr[8])           host_rdata <= rbank[host_addr[7]];
        else if (host_addr == 9'd0) host_rdata <= cfg;
        else if (host_addr == 9'd1) host_rdata <= {{(SW-2){1'b0}}, done, busy};
        else                        host_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_rd,
  input logic [8:0]    host_addr,
  input logic          host_rdata_en,
  input logic          busy,
  input logic          done,
  input logic          vis_pg,
  input logic [SW-1:0] cfg,
  input logic [8:0]    cnt
);
  wire arm_wr = host_sel && !host_rd && host_addr == 9'd1;

  p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && !busy) |=> (busy && !done));

  p_done_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm_wr) |=> done);

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_idle_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cnt == 9'd0);

  p_page_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> vis_pg != $past(vis_pg));

  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(vis_pg));

  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg));

  p_rden_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_rd) |=> host_rdata_en);

  p_rden_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_sel && host_rd) |=> !host_rdata_en);
endmodule

bind snap_capture snap_capture_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
  .host_addr(host_addr), .host_rdata_en(host_rdata_en), .busy(busy),
  .done(done), .vis_pg(vis_pg), .cfg(cfg), .cnt(cnt)
);

// File: tb/snap_capture_bench.sv
module snap_capture_bench;
  localparam int CLK_PERIOD = 10;
  // {layout[1:0], source, gap, seed[7:0]}
  localparam logic [11:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b0, 8'd11}, {2'd1, 1'b1, 1'b1, 8'd12},
    {2'd0, 1'b0, 1'b1, 8'd13}, {2'd0, 1'b1, 1'b0, 8'd14},
    {2'd2, 1'b0, 1'b0, 8'd15}, {2'd2, 1'b1, 1'b1, 8'd16},
    {2'd3, 1'b1, 1'b0, 8'd17}, {2'd3, 1'b0, 1'b1, 8'd18}
  };

  logic clk = 0, rst_n = 0;
  logic in_vld = 0, out_vld = 0, host_sel = 0, host_rd = 0;
  logic [15:0] in_a = 0, in_b = 0, out_a = 0, out_b = 0, host_wdata = 0;
  logic [8:0] host_addr = 0;
  logic [15:0] host_rdata;
  logic host_rdata_en;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_capture u_snap_capture (.*);

  function automatic logic [15:0] pat(input int s, input int lane, input int i);
    return 16'(s*977 + lane*4099 + i*263 + 5);
  endfunction

  function automatic logic [15:0] exp_word(input int lay, input int s, input int w);
    int lane, k;
    lane = (lay >= 2 && w >= 128) ? 1 : 0;
    k = (lay >= 2) ? w % 128 : w;
    if (lay == 1 || lay == 3) return pat(s, lane, k);
    return {pat(s, lane, 2*k+1)[15:8], pat(s, lane, 2*k)[15:8]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    host_sel = 1; host_rd = 0; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0;
  endtask

  task automatic hread(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    host_sel = 1; host_rd = 1; host_addr = a;
    @(negedge clk);
    host_sel = 0;
    d = host_rdata;
  endtask

  task automatic feed(input bit src, input bit gap, input int s, input int start, input int n);
    int got = 0;
    int c = 0;
    while (got < n) begin
      @(negedge clk);
      if (src) begin
        in_vld = 1; in_a = ~pat(s, 0, c); in_b = ~pat(s, 1, c);
      end else begin
        out_vld = 1; out_a = ~pat(s, 0, c); out_b = ~pat(s, 1, c);
      end
      if (gap && c % 3 == 2) begin
        if (src) out_vld = 0; else in_vld = 0;
      end else begin
        if (src) begin
          out_vld = 1; out_a = pat(s, 0, start+got); out_b = pat(s, 1, start+got);
        end else begin
          in_vld = 1; in_a = pat(s, 0, start+got); in_b = pat(s, 1, start+got);
        end
        got++;
      end
      c++;
    end
    @(negedge clk);
    in_vld = 0; out_vld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1 rdata_en", {15'b0, host_rdata_en}, 16'd0);
    hread(9'd1, d); chk("R1 status", d, 16'd0);
    hread(9'd0, d); chk("R1 control", d, 16'd0);

    foreach (VEC[v]) begin
      int lay, s, n, bad;
      bit src, gap;
      logic [15:0] fa, fe;
      lay = int'(VEC[v][11:10]); src = VEC[v][9]; gap = VEC[v][8]; s = int'(VEC[v][7:0]);
      n = (lay == 0) ? 512 : (lay == 3) ? 128 : 256;
      hwrite(9'd0, {13'b0, src, 2'(lay)});
      hwrite(9'd1, 16'd0);
      hread(9'd1, d); chk("R2 busy after arm", d, 16'd1);
      feed(src, gap, s, 0, n);
      hread(9'd1, d); chk("R3 done after length", d, 16'd2);
      bad = 0; fa = 0; fe = 0;
      for (int w = 0; w < 256; w++) begin
        hread(9'(256 + w), d);
        if (d !== exp_word(lay, s, w) && bad == 0) begin
          bad = 1; fa = d; fe = exp_word(lay, s, w);
        end
      end
      case (lay)
        0: chk("R6 R4 single narrow packing", fa, fe);
        1: chk("R5 R4 single wide order", fa, fe);
        2: chk("R6 R7 R4 dual narrow", fa, fe);
        default: chk("R7 R4 dual wide lanes", fa, fe);
      endcase
    end

    repeat (20) @(negedge clk);
    hread(9'd1, d); chk("R3 done persists", d, 16'd2);
    hread(9'd263, d);
    hwrite(9'd263, 16'h1234);
    begin
      logic [15:0] d2;
      hread(9'd263, d2); chk("R9 snapshot write ignored", d2, d);
    end
    hread(9'd1, d);
    chk("R10 rdata_en after read", {15'b0, host_rdata_en}, 16'd1);
    @(negedge clk);
    chk("R10 rdata_en idle", {15'b0, host_rdata_en}, 16'd0);
    hread(9'd5, d); chk("R10 unmapped control reads zero", d, 16'd0);

    hwrite(9'd0, 16'd1);
    hwrite(9'd1, 16'd0);
    feed(0, 0, 40, 0, 256);
    hwrite(9'd1, 16'd0);
    hread(9'd1, d); chk("R2 re-arm clears done", d, 16'd1);
    feed(0, 0, 41, 0, 100);
    hread(9'd1, d); chk("R3 not done early", d, 16'd1);
    hread(9'd266, d); chk("R8 old block during capture", d, pat(40, 0, 10));
    hwrite(9'd0, 16'd3);
    hread(9'd0, d); chk("R9 control locked while busy", d, 16'd1);
    hwrite(9'd1, 16'd0);
    feed(0, 0, 41, 100, 156);
    hread(9'd1, d); chk("R2 arm while busy ignored", d, 16'd2);
    hread(9'd266, d); chk("R8 new block visible", d, pat(41, 0, 10));
    hread(9'd456, d); chk("R8 new block late sample", d, pat(41, 0, 200));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule